// File: doc/BRIEF.md
# Dual-Accumulator ALU with Condition Flags

This block is the arithmetic and logic stage of a small 8-bit core. It holds two byte accumulators, called A and B, that can also be treated together as one 16-bit accumulator D. In D, A is the high byte and B is the low byte. Each cycle in which the write enable is high, the block applies one operation to the selected accumulator and an operand. The operand comes from memory or from an immediate field, and the caller supplies it. The block writes the result back and updates an 8-bit flag register.

A width select picks byte mode or word mode. In byte mode a destination select picks A or B, and only the low byte of the operand is used. The result of the current inputs is available combinationally every cycle. The accumulators and the flag register are registered, and their new values appear after the clock edge. Three control bits of the flag register (stop-disable, non-maskable mask and interrupt mask) are stored and passed through. Only an explicit flag-register load can change them.

Top module: `acc_alu_top`

## Requirements
- R1: D is the concatenation {A, B}. A word-mode write updates both A and B. A byte-mode write changes only the selected register (destination select 0 = A, 1 = B), and the other register keeps its value.
- R2: The flag byte is ordered from bit 7 to bit 0 as S, X, H, I, N, Z, V, C. After a synchronous reset, A = 0, B = 0 and the flag byte is 8'hD0.
- R3: ADD (op code 1) writes (reg + operand) mod 2^W. W is 8 in byte mode and 16 in word mode. C is the carry out of bit W-1. V is the carry into bit W-1 XOR the carry out of it.
- R4: SUB (op code 2) writes (reg - operand) mod 2^W. C is set when the operand is larger than the register, treating both as unsigned. V is set when the signed difference does not fit in W bits.
- R5: Every operation with op codes 0 to 7 sets N to bit W-1 of the result, and sets Z when the W-bit result is zero.
- R6: H is written only by a byte-mode ADD, and it takes the carry from bit 3 into bit 4. Every other operation, including every word-mode operation, leaves H unchanged.
- R7: AND (op code 3) and OR (op code 4) write the bitwise result, clear V and leave C unchanged.
- R8: SHL (op code 5) shifts left and fills bit 0 with 0. C takes the old bit W-1, and V = N XOR C. SHR (op code 6) shifts right logically, so N = 0. C takes the old bit 0, and V = C.
- R9: INC (op code 7) writes (reg + 1) mod 2^W. V is set only when the old value was 2^(W-1) - 1. C is unchanged.
- R10: LDFL (op code 8) loads all eight flag bits from the operand's low byte and leaves A and B unchanged. Its result output is the operand's low byte. No other operation changes S, X or I.
- R11: When the write enable is low, or the op code is 9 to 15, A, B and the flag byte all keep their values. An op code of 9 to 15 produces a result of 0.
- R12: LOAD (op code 0) writes the operand to the register. It updates N and Z, clears V and leaves C unchanged.
- R13: The result output is combinational from the current inputs and the current registers. In byte mode its upper byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| wide_i | input | 1 | 1 = word mode on D, 0 = byte mode |
| dst_b_i | input | 1 | Byte-mode destination: 0 = A, 1 = B |
| opnd_i | input | 16 | Memory or immediate operand |
| wr_en_i | input | 1 | Commit the result and flags at the clock edge |
| result_o | output | 16 | Combinational operation result |
| acc_a_o | output | 8 | Accumulator A |
| acc_b_o | output | 8 | Accumulator B |
| ccr_o | output | 8 | Flag register |

## Verification
In byte mode the bench sweeps every value of the register against a spread of operands, and in word mode it uses the boundary values 16'h7FFF, 16'h8000 and 16'hFFFF together with a pseudo-random set. The expected V is computed by a range check on signed sums, so a design that took V from the wrong carry, or gave increment a carry flag, is caught at the signed limits. Each of the 256 flag bytes is loaded and then followed by an ALU operation. This exposes any design that disturbs S, X or I, or that lets a word-mode operation or a subtraction write H. Idle cycles and undefined op codes are interleaved with the sweeps, and byte writes to A are checked for leaking into B.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [3:0] {
        OP_LOAD = 4'd0,
        OP_ADD  = 4'd1,
        OP_SUB  = 4'd2,
        OP_AND  = 4'd3,
        OP_OR   = 4'd4,
        OP_SHL  = 4'd5,
        OP_SHR  = 4'd6,
        OP_INC  = 4'd7,
        OP_LDFL = 4'd8
    } alu_op_e;

    // flag register, bit 7 first
    typedef struct packed {
        logic s;
        logic x;
        logic h;
        logic i;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    // flag outcome of one ALU operation plus which flags it may write
    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
        logic h;
        logic wr_c;
        logic wr_v;
        logic wr_h;
    } alu_flags_t;

    localparam ccr_t CCR_RESET = '{s: 1'b1, x: 1'b1, h: 1'b0, i: 1'b1,
                                   n: 1'b0, z: 1'b0, v: 1'b0, c: 1'b0};

    function automatic logic op_is_defined(input logic [3:0] code);
        return code <= 4'd8;
    endfunction

endpackage

// File: rtl/acc_alu_opsel.sv
module acc_alu_opsel
    import acc_alu_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic [BYTE_W-1:0] acc_a_i,
    input  logic [BYTE_W-1:0] acc_b_i,
    input  logic              wide_i,
    input  logic              dst_b_i,
    input  logic [WORD_W-1:0] opnd_i,
    output logic [WORD_W-1:0] lhs_o,
    output logic [WORD_W-1:0] rhs_o
);

    always_comb begin
        if (wide_i) begin
            lhs_o = {acc_a_i, acc_b_i};
            rhs_o = opnd_i;
        end else begin
            lhs_o = {{BYTE_W{1'b0}}, (dst_b_i ? acc_b_i : acc_a_i)};
            rhs_o = {{BYTE_W{1'b0}}, opnd_i[BYTE_W-1:0]};
        end
    end

endmodule

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
    import acc_alu_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W,
    localparam int N_WIDTHS = 2
) (
    input  alu_op_e           op_i,
    input  logic              wide_i,
    input  logic [WORD_W-1:0] lhs_i,
    input  logic [WORD_W-1:0] rhs_i,
    output logic [WORD_W-1:0] res_o,
    output alu_flags_t        flags_o
);

    logic [WORD_W-1:0] res_v  [N_WIDTHS];
    alu_flags_t        flag_v [N_WIDTHS];

    for (genvar g = 0; g < N_WIDTHS; g++) begin : g_width
        localparam int GW = BYTE_W * (g + 1);

        logic [GW-1:0] x_w;
        logic [GW-1:0] y_w;
        logic [GW-1:0] r_w;
        logic [GW:0]   sum_w;
        logic [GW:0]   dif_w;
        logic [GW-1:0] low_sum_w;
        logic [GW-1:0] low_dif_w;
        logic [4:0]    nib_w;
        logic          c_w, v_w, h_w, wc_w, wv_w, wh_w;

        assign x_w       = lhs_i[GW-1:0];
        assign y_w       = rhs_i[GW-1:0];
        assign sum_w     = {1'b0, x_w} + {1'b0, y_w};
        assign dif_w     = {1'b0, x_w} - {1'b0, y_w};
        // carry / borrow into the top bit
        assign low_sum_w = {1'b0, x_w[GW-2:0]} + {1'b0, y_w[GW-2:0]};
        assign low_dif_w = {1'b0, x_w[GW-2:0]} - {1'b0, y_w[GW-2:0]};
        assign nib_w     = {1'b0, x_w[3:0]} + {1'b0, y_w[3:0]};

        always_comb begin
            r_w  = '0;
            c_w  = 1'b0;
            v_w  = 1'b0;
            h_w  = 1'b0;
            wc_w = 1'b0;
            wv_w = 1'b0;
            wh_w = 1'b0;
            case (op_i)
                OP_LOAD: begin
                    r_w  = y_w;
                    wv_w = 1'b1;
                end
                OP_ADD: begin
                    r_w  = sum_w[GW-1:0];
                    c_w  = sum_w[GW];
                    v_w  = sum_w[GW] ^ low_sum_w[GW-1];
                    h_w  = nib_w[4];
                    wc_w = 1'b1;
                    wv_w = 1'b1;
                    wh_w = (g == 0);
                end
                OP_SUB: begin
                    r_w  = dif_w[GW-1:0];
                    c_w  = dif_w[GW];
                    v_w  = dif_w[GW] ^ low_dif_w[GW-1];
                    wc_w = 1'b1;
                    wv_w = 1'b1;
                end
                OP_AND: begin
                    r_w  = x_w & y_w;
                    wv_w = 1'b1;
                end
                OP_OR: begin
                    r_w  = x_w | y_w;
                    wv_w = 1'b1;
                end
                OP_SHL: begin
                    r_w  = {x_w[GW-2:0], 1'b0};
                    c_w  = x_w[GW-1];
                    v_w  = x_w[GW-1] ^ x_w[GW-2];
                    wc_w = 1'b1;
                    wv_w = 1'b1;
                end
                OP_SHR: begin
                    r_w  = {1'b0, x_w[GW-1:1]};
                    c_w  = x_w[0];
                    v_w  = x_w[0];
                    wc_w = 1'b1;
                    wv_w = 1'b1;
                end
                OP_INC: begin
                    r_w  = x_w + 1'b1;
                    v_w  = (x_w == {1'b0, {(GW-1){1'b1}}});
                    wv_w = 1'b1;
                end
                default: ;
            endcase
        end

        assign res_v[g]  = WORD_W'(r_w);
        assign flag_v[g] = '{n: r_w[GW-1], z: (r_w == '0), v: v_w, c: c_w,
                             h: h_w, wr_c: wc_w, wr_v: wv_w, wr_h: wh_w};
    end

    assign res_o   = wide_i ? res_v[1]  : res_v[0];
    assign flags_o = wide_i ? flag_v[1] : flag_v[0];

endmodule

// File: rtl/acc_alu_ccr.sv
module acc_alu_ccr
    import acc_alu_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  ccr_t              ccr_i,
    input  alu_op_e           op_i,
    input  logic              op_ok_i,
    input  alu_flags_t        flags_i,
    input  logic [BYTE_W-1:0] opnd_lo_i,
    output ccr_t              ccr_o
);

    always_comb begin
        ccr_o = ccr_i;
        if (op_i == OP_LDFL) begin
            ccr_o = ccr_t'(opnd_lo_i[7:0]);
        end else if (op_ok_i) begin
            ccr_o.n = flags_i.n;
            ccr_o.z = flags_i.z;
            if (flags_i.wr_c) ccr_o.c = flags_i.c;
            if (flags_i.wr_v) ccr_o.v = flags_i.v;
            if (flags_i.wr_h) ccr_o.h = flags_i.h;
        end
    end

endmodule

// File: rtl/acc_alu_top.sv
module acc_alu_top
    import acc_alu_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        op_i,
    input  logic              wide_i,
    input  logic              dst_b_i,
    input  logic [WORD_W-1:0] opnd_i,
    input  logic              wr_en_i,
    output logic [WORD_W-1:0] result_o,
    output logic [BYTE_W-1:0] acc_a_o,
    output logic [BYTE_W-1:0] acc_b_o,
    output logic [7:0]        ccr_o
);

    logic [BYTE_W-1:0] acc_a_q, acc_b_q;
    ccr_t              ccr_q, ccr_nx;
    alu_op_e           op;
    logic              op_ok;
    logic [WORD_W-1:0] lhs, rhs, alu_res;
    alu_flags_t        alu_fl;

    assign op    = alu_op_e'(op_i);
    assign op_ok = op_is_defined(op_i);

    acc_alu_opsel #(.BYTE_W(BYTE_W)) u_opsel (
        .acc_a_i (acc_a_q),
        .acc_b_i (acc_b_q),
        .wide_i  (wide_i),
        .dst_b_i (dst_b_i),
        .opnd_i  (opnd_i),
        .lhs_o   (lhs),
        .rhs_o   (rhs)
    );

    acc_alu_arith #(.BYTE_W(BYTE_W)) u_arith (
        .op_i    (op),
        .wide_i  (wide_i),
        .lhs_i   (lhs),
        .rhs_i   (rhs),
        .res_o   (alu_res),
        .flags_o (alu_fl)
    );

    acc_alu_ccr #(.BYTE_W(BYTE_W)) u_ccr (
        .ccr_i     (ccr_q),
        .op_i      (op),
        .op_ok_i   (op_ok),
        .flags_i   (alu_fl),
        .opnd_lo_i (opnd_i[BYTE_W-1:0]),
        .ccr_o     (ccr_nx)
    );

    assign result_o = (op == OP_LDFL) ? {{BYTE_W{1'b0}}, opnd_i[BYTE_W-1:0]} : alu_res;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_a_q <= '0;
            acc_b_q <= '0;
            ccr_q   <= CCR_RESET;
        end else if (wr_en_i && op_ok) begin
            ccr_q <= ccr_nx;
            if (op != OP_LDFL) begin
                if (wide_i) begin
                    acc_a_q <= alu_res[WORD_W-1:BYTE_W];
                    acc_b_q <= alu_res[BYTE_W-1:0];
                end else if (dst_b_i) begin
                    acc_b_q <= alu_res[BYTE_W-1:0];
                end else begin
                    acc_a_q <= alu_res[BYTE_W-1:0];
                end
            end
        end
    end

    assign acc_a_o = acc_a_q;
    assign acc_b_o = acc_b_q;
    assign ccr_o   = ccr_q;

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en_i || !op_ok) |=> ($stable(acc_a_q) && $stable(acc_b_q) && $stable(ccr_q)));

    // R10
    ctrl_bits_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (op != OP_LDFL) |=> (ccr_q.s == $past(ccr_q.s) && ccr_q.x == $past(ccr_q.x)
                             && ccr_q.i == $past(ccr_q.i)));

    // R6
    wide_h_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wide_i && op != OP_LDFL) |=> (ccr_q.h == $past(ccr_q.h)));

    // R7
    logic_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && (op == OP_AND || op == OP_OR))
        |=> (!ccr_q.v && ccr_q.c == $past(ccr_q.c)));

    // R9
    inc_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && op == OP_INC) |=> (ccr_q.c == $past(ccr_q.c)));

    // R1
    byte_a_keeps_b_chk: assert property (@(posedge clk) disable iff (rst)
        (!wide_i && !dst_b_i) |=> (acc_b_q == $past(acc_b_q)));

endmodule

// File: tb/tb_acc_alu_top.sv
module tb_acc_alu_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  op_i;
    logic        wide_i, dst_b_i, wr_en_i;
    logic [15:0] opnd_i;
    logic [15:0] result_o;
    logic [7:0]  acc_a_o, acc_b_o, ccr_o;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    int ma, mb, mccr;   // reference model state
    int lcg = 32'h1234_5678;

    always #2.5 clk = ~clk;

    acc_alu_top dut (
        .clk(clk), .rst(rst), .op_i(op_i), .wide_i(wide_i), .dst_b_i(dst_b_i),
        .opnd_i(opnd_i), .wr_en_i(wr_en_i), .result_o(result_o),
        .acc_a_o(acc_a_o), .acc_b_o(acc_b_o), .ccr_o(ccr_o)
    );

    function automatic int next_rand();
        lcg = lcg * 1103515245 + 12345;
        return (lcg >>> 8) & 16'hFFFF;
    endfunction

    function automatic string tag_of(int op, bit wide, bit wr);
        string t;
        if (!wr || op > 8) t = "R11";
        else case (op)
            0: t = "R12 R5";
            1: t = "R3 R5 R6";
            2: t = "R4 R5 R6";
            3, 4: t = "R7 R5";
            5, 6: t = "R8 R5";
            7: t = "R9 R5";
            default: t = "R10";
        endcase
        return wide ? {t, " R1 R13"} : {t, " R1 R13"};
    endfunction

    // one vector: drive, check combinational result, clock, check state
    task automatic apply(int op, bit wide, bit dstb, int opnd, bit wr);
        int full, half, m, x, y, r, sx, sy, s, fl, c, v, h, n, exp_res;
        int na, nb, nccr;
        bit bad;
        string tag;
        @(negedge clk);
        op_i = op[3:0]; wide_i = wide; dst_b_i = dstb;
        opnd_i = opnd[15:0]; wr_en_i = wr;
        full = wide ? 65536 : 256;
        half = full / 2;
        m    = full - 1;
        x    = wide ? (ma * 256 + mb) : (dstb ? mb : ma);
        y    = opnd & m;
        sx   = (x >= half) ? x - full : x;
        sy   = (y >= half) ? y - full : y;
        fl   = mccr;
        c = fl & 1; v = (fl >> 1) & 1; h = (fl >> 5) & 1;
        r = 0;
        case (op)
            0: begin r = y; v = 0; end
            1: begin r = (x + y) & m; c = (x + y) > m ? 1 : 0;
                     s = sx + sy; v = (s >= half || s < -half) ? 1 : 0;
                     if (!wide) h = ((x & 15) + (y & 15)) > 15 ? 1 : 0; end
            2: begin r = (x - y) & m; c = (x < y) ? 1 : 0;
                     s = sx - sy; v = (s >= half || s < -half) ? 1 : 0; end
            3: begin r = x & y; v = 0; end
            4: begin r = x | y; v = 0; end
            5: begin r = (x * 2) & m; c = (x >= half) ? 1 : 0;
                     v = ((r >= half) ? 1 : 0) ^ c; end
            6: begin r = x / 2; c = x % 2; v = c; end
            7: begin r = (x + 1) & m; v = (x == half - 1) ? 1 : 0; end
            8: r = opnd & 255;
            default: r = 0;
        endcase
        exp_res = r;
        n = (r >= half) ? 1 : 0;
        na = ma; nb = mb; nccr = mccr;
        if (wr && op <= 8) begin
            if (op == 8) nccr = opnd & 255;
            else begin
                nccr = (fl & 8'hD0) | (h << 5) | (n << 3) | ((r == 0) << 2) | (v << 1) | c;
                if (wide) begin na = r / 256; nb = r % 256; end
                else if (dstb) nb = r;
                else na = r;
            end
        end
        tag = tag_of(op, wide, wr);
        bad = 1'b0;
        #1;
        if (result_o !== exp_res[15:0]) begin
            $display("FAIL %s: op=%0d wide=%0d result %h expected %h", tag, op, wide, result_o, exp_res[15:0]);
            bad = 1'b1;
        end
        @(posedge clk);
        #1;
        if (acc_a_o !== na[7:0] || acc_b_o !== nb[7:0] || ccr_o !== nccr[7:0]) begin
            $display("FAIL %s: op=%0d wide=%0d dst_b=%0d opnd=%h A/B/F %h/%h/%h expected %h/%h/%h",
                     tag, op, wide, dstb, opnd[15:0], acc_a_o, acc_b_o, ccr_o,
                     na[7:0], nb[7:0], nccr[7:0]);
            bad = 1'b1;
        end
        ma = na; mb = nb; mccr = nccr;
        n_vec++;
        if (bad) n_fail++;
    endtask

    initial begin
        int corner [7] = '{0, 1, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h00FF, 16'h0F0F};
        rst = 1'b1; op_i = 4'd0; wide_i = 1'b0; dst_b_i = 1'b0; opnd_i = '0; wr_en_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R2: reset state
        n_vec++;
        if (acc_a_o !== 8'h00 || acc_b_o !== 8'h00 || ccr_o !== 8'hD0) begin
            $display("FAIL R2: A/B/F %h/%h/%h expected 00/00/d0", acc_a_o, acc_b_o, ccr_o);
            n_fail++;
        end
        ma = 0; mb = 0; mccr = 8'hD0;

        // R10 R6: every flag byte loaded, then an ALU op must keep S/X/I and H rules
        for (int f = 0; f < 256; f++) begin
            apply(8, 1'b0, 1'b0, 16'hAB00 | f, 1'b1);
            apply(1 + (f % 7), f[1], f[2], (f * 37) & 16'hFFFF, 1'b1);
        end

        // R3 R4 R7 R8 R9 R12 R1: byte mode, every register value, spread of operands
        for (int a = 0; a < 256; a++) begin
            for (int k = 0; k < 18; k++) begin
                for (int op = 1; op <= 7; op++) begin
                    apply(0, 1'b0, k[0], a | 16'h5A00, 1'b1);
                    apply(op, 1'b0, k[0], (k * 15) | ((a * 3) << 8), 1'b1);
                end
            end
        end

        // word mode corners (signed limits for V, carries through byte boundary)
        for (int i = 0; i < 7; i++) begin
            for (int j = 0; j < 7; j++) begin
                for (int op = 1; op <= 7; op++) begin
                    apply(0, 1'b1, 1'b0, corner[i], 1'b1);
                    apply(op, 1'b1, 1'b0, corner[j], 1'b1);
                end
            end
        end

        // word mode pseudo-random
        for (int i = 0; i < 800; i++) begin
            int xv, yv;
            xv = next_rand();
            yv = next_rand();
            for (int op = 1; op <= 7; op++) begin
                apply(0, 1'b1, 1'b0, xv, 1'b1);
                apply(op, 1'b1, 1'b0, yv, 1'b1);
            end
        end

        // R11: idle cycles and undefined codes must leave state untouched
        for (int i = 0; i < 300; i++) begin
            int rv;
            rv = next_rand();
            apply(0, 1'b1, 1'b0, next_rand(), 1'b1);
            apply(rv % 16, rv[4], rv[5], next_rand(), 1'b0);
            apply(9 + (rv % 7), rv[6], rv[7], next_rand(), 1'b1);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule